// File: doc/BRIEF.md
# Framed Serial Register Port with Data-Ready Flag

This block is the slave side of a synchronous serial port for a converter-style device. An external master supplies the serial clock and two active-low framing strobes, one for reads and one for writes. Every input is oversampled into the system clock domain. Within a frame the block shifts data out on falling serial-clock edges, and the master samples that data on rising edges. Data written by the master is captured on rising edges. An address line picks the bank. When it is low, the 24-bit control register is selected. When it is high, either the conversion output register or one of a small set of 24-bit calibration registers is selected, according to a bank-select input and an index input.

New conversion results arrive as a one-cycle valid pulse with a data word. An active-low data-ready output reports that a fresh word is waiting. The flag obeys strict rules. It clears only after the final bit of the output word has been shifted out. A read of the output word may be spread over several frames. A word that arrives while an output read is under way is discarded. An output read that starts while the flag is inactive transfers nothing. Bit 0 of the control register sets the output word length: 16 or 24 bits.

Top module: `ser_reg_port`

## Requirements
- R1: After reset, `drdy_n_o` is high, `sdo_o` is low, and the control register holds zero, which selects 16-bit output words.
- R2: An accepted `conv_valid_i` pulse loads `conv_word_i` and drives `drdy_n_o` low. An unread word is replaced by each later accepted word, and a read returns the most recent one.
- R3: A read frame with `addr_i` low shifts out the 24-bit control register, MSB first, and leaves `drdy_n_o` unchanged.
- R4: A read frame with `addr_i` high and `cal_sel_i` high shifts out the 24-bit calibration register chosen by `cal_idx_i`, MSB first, and leaves `drdy_n_o` unchanged.
- R5: A write frame captures 24 bits, MSB first, on rising serial-clock edges. With `addr_i` low they go to the control register, and with `addr_i` high to the calibration register chosen by `cal_idx_i`. A frame that ends before 24 bits changes nothing. Writes neither wait for nor change `drdy_n_o`.
- R6: With control bit 0 at 1, the output word is all 24 bits. With it at 0, the output word is the upper 16 bits (23:8), MSB first. `drdy_n_o` returns high only after the rising edge of the last bit of the word.
- R7: An output read split across several frames resumes at the first bit that has not yet been read.
- R8: A word that arrives while an output read frame is open, or while a partially read word is pending, is dropped and never raises `drdy_n_o`.
- R9: An output-register read frame (`addr_i` high, `cal_sel_i` low) that begins while `drdy_n_o` is high keeps `sdo_o` low and consumes nothing.
- R10: `sdo_o` changes only after a serial-clock falling edge or at the start of a frame. It is stable across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the master, idles low |
| rd_n_i | input | 1 | Read frame strobe, active low |
| wr_n_i | input | 1 | Write frame strobe, active low |
| addr_i | input | 1 | Bank address: 0 control, 1 output/calibration |
| cal_sel_i | input | 1 | With `addr_i` high: 0 output register, 1 calibration |
| cal_idx_i | input | IW | Calibration register index |
| sdi_i | input | 1 | Serial write data |
| sdo_o | output | 1 | Serial read data |
| drdy_n_o | output | 1 | Data-ready flag, active low |
| conv_valid_i | input | 1 | One-cycle pulse: a new conversion word is present |
| conv_word_i | input | DW | New conversion word |

## Verification
A corrupted bit pointer shows up as a rotated or shifted serial word within the same frame. A split read makes this worse, because the misplaced bits come back in the following frame. A stale busy indication has two possible symptoms. Either a word that should be dropped overwrites the pending one, or a refused frame drives data on `sdo_o`. Both appear at the next frame. A wrong data-ready state is visible on `drdy_n_o` within a few system clocks of the triggering serial edge or valid pulse. That is why the flag is sampled before and after the last bit of each output read.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic [2:0] {
    FK_IDLE,
    FK_CTRL,
    FK_CAL,
    FK_OUT,
    FK_WR,
    FK_DONE
  } frame_kind_e;
endpackage

// File: rtl/srp_sync_bus.sv
module srp_sync_bus #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/srp_reg_bank.sv
module srp_reg_bank #(
  parameter int DW = 24,
  parameter int NCAL = 2,
  parameter int IW = 1,
  parameter logic [DW-1:0] CTRL_RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          to_ctrl,
  input  logic [IW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] cal_q
);
  logic [DW-1:0] cal_mem [NCAL];

  always_ff @(posedge clk) begin
    if (rst)                ctrl_q <= CTRL_RST;
    else if (we && to_ctrl) ctrl_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (we && !to_ctrl) cal_mem[idx] <= wdata;
  end

  assign cal_q = cal_mem[idx];

  // R5: control contents move only on a completed control write
  a_r5_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
    !(we && to_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/srp_out_word.sv
module srp_out_word #(
  parameter int DW = 24,
  parameter int SHORT_W = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_v,
  input  logic [DW-1:0] load_w,
  input  logic          wl24,
  input  logic          frame_out,
  input  logic          adv,
  output logic [DW-1:0] word,
  output logic [CW-1:0] ptr,
  output logic          out_last,
  output logic          drdy_n
);
  localparam logic [CW-1:0] LAST_LONG  = CW'(DW - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(SHORT_W - 1);

  logic busy, accept;
  assign busy     = frame_out || (ptr != '0);
  assign accept   = load_v && !busy;
  assign out_last = ptr >= (wl24 ? LAST_LONG : LAST_SHORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      word   <= '0;
      ptr    <= '0;
      drdy_n <= 1'b1;
    end else if (accept) begin
      word   <= load_w;
      ptr    <= '0;
      drdy_n <= 1'b0;
    end else if (adv) begin
      if (out_last) begin
        ptr    <= '0;
        drdy_n <= 1'b1;
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  // R2: the flag only becomes active after a word arrives
  a_r2_fall_after_load: assert property (@(posedge clk) disable iff (rst)
    $fell(drdy_n) |-> $past(load_v));
  // R6: the flag only clears after a bit is shifted out
  a_r6_rise_after_shift: assert property (@(posedge clk) disable iff (rst)
    $rose(drdy_n) |-> $past(adv));
  // R7: with no word pending no partial-read position is held
  a_r7_idle_pointer: assert property (@(posedge clk) disable iff (rst)
    drdy_n |-> (ptr == '0));
  // R8: a word arriving during an output read leaves the held word intact
  a_r8_drop_in_frame: assert property (@(posedge clk) disable iff (rst)
    (load_v && frame_out) |=> $stable(word));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port
  import srp_pkg::*;
#(
  parameter int DW = 24,
  parameter int SHORT_W = 16,
  parameter int NCAL = 2,
  parameter int WL_BIT = 0,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-1:0] CTRL_RST = '0,
  localparam int IW = (NCAL > 1) ? $clog2(NCAL) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sclk_i,
  input  logic          rd_n_i,
  input  logic          wr_n_i,
  input  logic          addr_i,
  input  logic          cal_sel_i,
  input  logic [IW-1:0] cal_idx_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          drdy_n_o,
  input  logic          conv_valid_i,
  input  logic [DW-1:0] conv_word_i
);
  localparam int CW = $clog2(DW);
  localparam int SBW = 6 + IW;
  localparam logic [SBW-1:0] SYNC_RST = SBW'(6);
  localparam logic [CW-1:0] BIT_LAST = CW'(DW - 1);

  logic [SBW-1:0] raw, syn;
  logic sclk_s, rd_s, wr_s, sdi_s, addr_s, csel_s;
  logic [IW-1:0] idx_s;
  logic sclk_p, rd_p, wr_p;
  logic sclk_rise, sclk_fall, rd_fall, wr_fall;

  assign raw = {cal_idx_i, cal_sel_i, addr_i, sdi_i, wr_n_i, rd_n_i, sclk_i};

  srp_sync_bus #(.W(SBW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst), .din(raw), .dout(syn)
  );

  assign {idx_s, csel_s, addr_s, sdi_s, wr_s, rd_s, sclk_s} = syn;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= 1'b0;
      rd_p   <= 1'b1;
      wr_p   <= 1'b1;
    end else begin
      sclk_p <= sclk_s;
      rd_p   <= rd_s;
      wr_p   <= wr_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_p;
  assign sclk_fall = ~sclk_s & sclk_p;
  assign rd_fall   = ~rd_s & rd_p;
  assign wr_fall   = ~wr_s & wr_p;

  frame_kind_e   kind;
  logic [CW-1:0] bcnt;
  logic [DW-1:0] shreg;
  logic          addr_q, start_q, sdo_q;
  logic [IW-1:0] idx_q;

  logic [DW-1:0] ctrl_q, cal_q, out_word;
  logic [CW-1:0] out_ptr;
  logic          out_last, drdy_n;
  logic          we, adv, frame_out;
  logic [DW-1:0] wdata;

  assign frame_out = (kind == FK_OUT);
  assign adv       = frame_out && sclk_rise;
  assign we        = (kind == FK_WR) && sclk_rise && (bcnt == BIT_LAST);
  assign wdata     = {shreg[DW-2:0], sdi_s};

  srp_reg_bank #(.DW(DW), .NCAL(NCAL), .IW(IW), .CTRL_RST(CTRL_RST)) u_regs (
    .clk(clk), .rst(rst), .we(we), .to_ctrl(!addr_q), .idx(idx_q),
    .wdata(wdata), .ctrl_q(ctrl_q), .cal_q(cal_q)
  );

  srp_out_word #(.DW(DW), .SHORT_W(SHORT_W), .CW(CW)) u_out (
    .clk(clk), .rst(rst), .load_v(conv_valid_i), .load_w(conv_word_i),
    .wl24(ctrl_q[WL_BIT]), .frame_out(frame_out), .adv(adv),
    .word(out_word), .ptr(out_ptr), .out_last(out_last), .drdy_n(drdy_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      kind    <= FK_IDLE;
      bcnt    <= '0;
      shreg   <= '0;
      addr_q  <= 1'b0;
      idx_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      if (kind == FK_IDLE) begin
        if (rd_fall) begin
          addr_q  <= addr_s;
          idx_q   <= idx_s;
          bcnt    <= '0;
          start_q <= 1'b1;
          if (!addr_s)     kind <= FK_CTRL;
          else if (csel_s) kind <= FK_CAL;
          else if (!drdy_n) kind <= FK_OUT;
          else             kind <= FK_DONE;
        end else if (wr_fall) begin
          addr_q  <= addr_s;
          idx_q   <= idx_s;
          bcnt    <= '0;
          start_q <= 1'b1;
          kind    <= FK_WR;
        end
      end else if (rd_s && wr_s) begin
        kind <= FK_IDLE;
      end else if (sclk_rise) begin
        case (kind)
          FK_CTRL, FK_CAL: begin
            if (bcnt == BIT_LAST) kind <= FK_DONE;
            else                  bcnt <= bcnt + 1'b1;
          end
          FK_OUT: if (out_last) kind <= FK_DONE;
          FK_WR: begin
            shreg <= wdata;
            if (bcnt == BIT_LAST) kind <= FK_DONE;
            else                  bcnt <= bcnt + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  logic [DW-1:0] src;
  logic [CW-1:0] pos;
  always_comb begin
    case (kind)
      FK_CTRL: src = ctrl_q;
      FK_CAL:  src = cal_q;
      FK_OUT:  src = out_word;
      default: src = '0;
    endcase
    pos = BIT_LAST - ((kind == FK_OUT) ? out_ptr : bcnt);
  end

  always_ff @(posedge clk) begin
    if (rst)                        sdo_q <= 1'b0;
    else if (kind == FK_IDLE)       sdo_q <= 1'b0;
    else if (start_q || sclk_fall)  sdo_q <= src[pos];
  end

  assign sdo_o    = sdo_q;
  assign drdy_n_o = drdy_n;

  // R9: an output transfer only runs while a word is pending
  a_r9_out_needs_ready: assert property (@(posedge clk) disable iff (rst)
    (kind == FK_OUT) |-> !drdy_n);
  // R10: inside a frame the serial output moves only after a falling edge or at the start
  a_r10_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    (!$stable(sdo_q) && $past(kind) != FK_IDLE) |-> $past(start_q || sclk_fall));
endmodule

// File: tb/sim_ser_reg_port.sv
`timescale 1ns/1ps
module sim_ser_reg_port;
  localparam int IW = 1;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, rd_n = 1'b1, wr_n = 1'b1, addr = 1'b0, csel = 1'b0, sdi = 1'b0;
  logic [IW-1:0] cidx = '0;
  logic sdo, drdy_n;
  logic cvalid = 1'b0;
  logic [23:0] cword = '0;

  int checks = 0;
  int fails = 0;
  int unstable = 0;

  always #2.5 clk = ~clk;

  ser_reg_port u0 (
    .clk(clk), .rst(rst), .sclk_i(sclk), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .addr_i(addr), .cal_sel_i(csel), .cal_idx_i(cidx), .sdi_i(sdi),
    .sdo_o(sdo), .drdy_n_o(drdy_n), .conv_valid_i(cvalid), .conv_word_i(cword)
  );

  task automatic chk(input logic ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sbit(input logic din, output logic dout);
    sdi = din;
    repeat (HALF) @(negedge clk);
    dout = sdo;
    sclk = 1'b1;
    repeat (3) @(negedge clk);
    if (sdo !== dout) unstable++;
    repeat (HALF - 3) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic rd_frame(input logic a, input logic cs, input logic [IW-1:0] ix, input int n, output logic [23:0] d);
    logic b;
    d = '0;
    addr = a; csel = cs; cidx = ix;
    @(negedge clk); rd_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sbit(1'b0, b);
      d = {d[22:0], b};
    end
    repeat (HALF) @(negedge clk);
    rd_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic wr_frame(input logic a, input logic [IW-1:0] ix, input logic [23:0] v, input int n);
    logic b;
    addr = a; cidx = ix;
    @(negedge clk); wr_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < n; i++) sbit(v[23-i], b);
    repeat (HALF) @(negedge clk);
    wr_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic push(input logic [23:0] w);
    @(negedge clk); cvalid = 1'b1; cword = w;
    @(negedge clk); cvalid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [23:0] d;
    chk(drdy_n === 1'b1, "R1 drdy after reset", {23'd0, drdy_n}, 24'd1);
    chk(sdo === 1'b0, "R1 sdo after reset", {23'd0, sdo}, 24'd0);
    rd_frame(1'b0, 1'b0, '0, 24, d);
    chk(d === 24'h000000, "R1 R3 control reset value", d, 24'h000000);
  endtask

  task automatic t_ctrl();
    logic [23:0] d;
    wr_frame(1'b0, '0, 24'h5A3C01, 24);
    chk(drdy_n === 1'b1, "R5 write leaves drdy", {23'd0, drdy_n}, 24'd1);
    rd_frame(1'b0, 1'b0, '0, 24, d);
    chk(d === 24'h5A3C01, "R3 R5 control readback", d, 24'h5A3C01);
    wr_frame(1'b0, '0, 24'hFFFFFF, 12);
    rd_frame(1'b0, 1'b0, '0, 24, d);
    chk(d === 24'h5A3C01, "R5 short write discarded", d, 24'h5A3C01);
  endtask

  task automatic t_cal();
    logic [23:0] d;
    wr_frame(1'b1, 1'b1, 24'h123456, 24);
    wr_frame(1'b1, 1'b0, 24'hABCDEF, 24);
    rd_frame(1'b1, 1'b1, 1'b0, 24, d);
    chk(d === 24'hABCDEF, "R4 cal0 readback", d, 24'hABCDEF);
    rd_frame(1'b1, 1'b1, 1'b1, 24, d);
    chk(d === 24'h123456, "R4 cal1 readback", d, 24'h123456);
    chk(drdy_n === 1'b1, "R4 cal read leaves drdy", {23'd0, drdy_n}, 24'd1);
  endtask

  task automatic t_out_split();
    logic [23:0] d1, d2, got;
    push(24'h89ABCD);
    push(24'h13579B);
    chk(drdy_n === 1'b0, "R2 drdy active on load", {23'd0, drdy_n}, 24'd0);
    rd_frame(1'b1, 1'b0, '0, 10, d1);
    chk(drdy_n === 1'b0, "R6 drdy held before last bit", {23'd0, drdy_n}, 24'd0);
    rd_frame(1'b1, 1'b0, '0, 14, d2);
    got = {d1[9:0], d2[13:0]};
    chk(got === 24'h13579B, "R2 R7 split read newest word", got, 24'h13579B);
    chk(drdy_n === 1'b1, "R6 drdy cleared after 24th bit", {23'd0, drdy_n}, 24'd1);
  endtask

  task automatic t_side_reads();
    logic [23:0] d;
    push(24'h2468AC);
    rd_frame(1'b0, 1'b0, '0, 24, d);
    chk(drdy_n === 1'b0, "R3 control read leaves drdy low", {23'd0, drdy_n}, 24'd0);
    rd_frame(1'b1, 1'b1, 1'b0, 24, d);
    chk(drdy_n === 1'b0, "R4 cal read leaves drdy low", {23'd0, drdy_n}, 24'd0);
    wr_frame(1'b1, 1'b0, 24'hABCDEF, 24);
    chk(drdy_n === 1'b0, "R5 write leaves drdy low", {23'd0, drdy_n}, 24'd0);
    rd_frame(1'b1, 1'b0, '0, 24, d);
    chk(d === 24'h2468AC, "R2 output word intact", d, 24'h2468AC);
  endtask

  task automatic t_refused();
    logic [23:0] d;
    rd_frame(1'b1, 1'b0, '0, 8, d);
    chk(d === 24'h000000, "R9 refused read keeps sdo low", d, 24'h000000);
    chk(drdy_n === 1'b1, "R9 refused read leaves drdy", {23'd0, drdy_n}, 24'd1);
    push(24'h0F1E2D);
    rd_frame(1'b1, 1'b0, '0, 24, d);
    chk(d === 24'h0F1E2D, "R9 nothing consumed", d, 24'h0F1E2D);
  endtask

  task automatic t_drop();
    logic [23:0] d1, d2, got;
    push(24'hC0FFEE);
    rd_frame(1'b1, 1'b0, '0, 8, d1);
    push(24'hBADBAD);
    chk(drdy_n === 1'b0, "R8 drdy still low", {23'd0, drdy_n}, 24'd0);
    rd_frame(1'b1, 1'b0, '0, 16, d2);
    got = {d1[7:0], d2[15:0]};
    chk(got === 24'hC0FFEE, "R8 word during partial read dropped", got, 24'hC0FFEE);
    rd_frame(1'b1, 1'b0, '0, 24, got);
    chk(got === 24'h000000 && drdy_n === 1'b1, "R8 dropped word not flagged", got, 24'h000000);
    push(24'h7E57ED);
    fork
      rd_frame(1'b1, 1'b0, '0, 24, got);
      begin repeat (100) @(negedge clk); push(24'hDEAD01); end
    join
    chk(got === 24'h7E57ED, "R8 word during open frame dropped", got, 24'h7E57ED);
    chk(drdy_n === 1'b1, "R8 drdy high after drop", {23'd0, drdy_n}, 24'd1);
  endtask

  task automatic t_short();
    logic [23:0] d1, d2, got;
    wr_frame(1'b0, '0, 24'h000000, 24);
    push(24'hFEDCBA);
    rd_frame(1'b1, 1'b0, '0, 15, d1);
    chk(drdy_n === 1'b0, "R6 drdy held after 15 bits", {23'd0, drdy_n}, 24'd0);
    rd_frame(1'b1, 1'b0, '0, 1, d2);
    chk(drdy_n === 1'b1, "R6 drdy cleared after 16th bit", {23'd0, drdy_n}, 24'd1);
    got = {8'h00, d1[14:0], d2[0]};
    chk(got === 24'h00FEDC, "R6 R7 16-bit word", got, 24'h00FEDC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_cal();
    t_out_split();
    t_side_reads();
    t_refused();
    t_drop();
    t_short();
    chk(unstable == 0, "R10 sdo stable across rising edges", 24'(unstable), 24'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule